// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one inter-processor interrupt command into the set of agents that must receive it. A command arrives as two 32-bit words plus the ID of the agent that issued it. The block decodes the vector, delivery mode, level and trigger fields. It then resolves the destination against a parameterised population of agents. Each agent is identified by its index and is described by an 8-bit logical ID and a 4-bit addressing-format code. The result is one bit per agent.

Destinations can be given in several ways. A destination can be a physical index or the physical broadcast value. It can also be a logical address, which each agent matches under either a flat or a clustered scheme. A shorthand can replace the destination field and name the sender itself, every agent, or every agent except the sender. Two delivery modes reshape the resolved set. Lowest-priority delivery keeps only the lowest-indexed candidate. A de-asserting INIT produces no targets.

The command is accepted on a valid strobe. One cycle later the mask and the decoded fields appear on registered outputs, together with a one-cycle valid pulse. An empty result is still reported, and a separate flag marks it as empty.

Top module: `ipi_dest_resolver`

## Requirements
- R1: On an accepted command, the outputs carry the fields of the low word: vector from bits 7:0, delivery mode from bits 10:8, level from bit 14 and trigger from bit 15. The decode is the same for every delivery mode, so a startup command (mode 6) passes its vector to all of its targets. Low-word bits 12, 13, 16, 17 and 20..31, and high-word bits 0..23, never affect any output.
- R2: With shorthand 0 (low-word bits 19:18), physical addressing (low-word bit 11 = 0) and a destination (high-word bits 31:24) other than 0xFF, only the agent whose index equals the destination is set. A destination at or above the agent count gives an empty mask.
- R3: With shorthand 0, physical addressing and destination 0xFF, every agent is set.
- R4: With shorthand 0 and logical addressing (bit 11 = 1), an agent whose format code is 0xF is set when the destination ANDed with its logical ID is nonzero.
- R5: With shorthand 0 and logical addressing, an agent whose format code is 0x0 is set when the upper nibbles of the destination and its logical ID are equal and the lower nibbles share at least one set bit. An agent with any other format code is never set by logical addressing.
- R6: Shorthand 1 sets only the agent whose index equals the sender ID. If the sender ID is not a valid index, the mask is empty.
- R7: Shorthand 2 sets every agent.
- R8: Shorthand 3 sets every agent except the one whose index equals the sender ID.
- R9: With delivery mode 1 (lowest priority), only the lowest-indexed bit of the resolved mask is kept.
- R10: Delivery mode 5 with level 0 and trigger 1 gives an empty mask, whatever the destination and shorthand. Mode 5 with any other level and trigger combination resolves normally.
- R11: out_valid pulses for exactly the one cycle after each clock edge at which cmd_valid is high. When no command is accepted, the mask, the flag and the fields keep their values.
- R12: Whenever out_valid is high, out_empty is high exactly when out_mask is all zero.
- R13: While reset is applied, out_valid, out_mask and out_empty are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command strobe; the words are taken on this edge |
| cmd_lo | input | 32 | Low command word (vector, mode, addressing, level, trigger, shorthand) |
| cmd_hi | input | 32 | High command word (destination in bits 31:24) |
| sender_id | input | 8 | ID of the issuing agent |
| agent_ldest | input | N_AGENTS*8 | Logical ID of each agent, agent i in bits 8i+7:8i |
| agent_model | input | N_AGENTS*4 | Addressing-format code of each agent, agent i in bits 4i+3:4i |
| out_valid | output | 1 | One-cycle pulse when a result is presented |
| out_mask | output | N_AGENTS | Resolved target set, bit i for agent i |
| out_empty | output | 1 | The presented mask is all zero |
| out_vector | output | 8 | Decoded vector |
| out_mode | output | 3 | Decoded delivery mode |
| out_level | output | 1 | Decoded level bit |
| out_trigger | output | 1 | Decoded trigger bit |

## Verification
In a single cycle, the destination selection (shorthand or addressing match) and the delivery-mode rewrite (lowest-priority narrowing or INIT de-assert suppression) both act on the same command. The bench provokes every pairing by crossing all four shorthands and both addressing kinds with delivery modes 0, 1, 5 and 6 over all 256 destination values. Level, trigger and sender ID vary with the destination, so the de-assert combination and out-of-range senders occur inside every pairing. Each result is compared with a mask that the bench computes first from the selection rule and then passes through the mode rule.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int ID_W  = 8;
  localparam int FMT_W = 4;

  // Field positions inside the command words
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int LOGIC_BIT = 11;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_LOWEST  = 3'd1;
  localparam logic [2:0] DM_INIT    = 3'd5;
  localparam logic [2:0] DM_STARTUP = 3'd6;

  typedef struct packed {
    logic [7:0]      vector;
    logic [2:0]      mode;
    logic            logical;
    logic            level;
    logic            trigger;
    shorthand_e      sh;
    logic [ID_W-1:0] dest;
  } ipi_cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
(
  input  logic [31:0] cmd_lo,
  input  logic [31:0] cmd_hi,
  output ipi_cmd_t    cmd
);

  always_comb begin
    cmd.vector  = cmd_lo[VEC_LSB +: 8];
    cmd.mode    = cmd_lo[MODE_LSB +: 3];
    cmd.logical = cmd_lo[LOGIC_BIT];
    cmd.level   = cmd_lo[LEVEL_BIT];
    cmd.trigger = cmd_lo[TRIG_BIT];
    cmd.sh      = shorthand_e'(cmd_lo[SH_LSB +: 2]);
    cmd.dest    = cmd_hi[DEST_LSB +: ID_W];
  end

  // Reserved command bits carry no meaning for target resolution
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_lo[13:12], cmd_lo[17:16], cmd_lo[31:20],
                             cmd_hi[DEST_LSB-1:0]};

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 16
) (
  input  logic [ID_W-1:0]           dest,
  input  logic                      logical,
  input  logic [N_AGENTS*ID_W-1:0]  agent_ldest,
  input  logic [N_AGENTS*FMT_W-1:0] agent_model,
  output logic [N_AGENTS-1:0]       addr_hit
);

  localparam int              HALF      = ID_W / 2;
  localparam logic [ID_W-1:0] BCAST     = '1;
  localparam logic [FMT_W-1:0] FMT_FLAT = '1;
  localparam logic [FMT_W-1:0] FMT_CLUS = '0;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    localparam logic [ID_W-1:0] IDX = ID_W'(g);
    logic [ID_W-1:0]  ld;
    logic [FMT_W-1:0] md;
    logic phys_hit, flat_hit, clus_hit, log_hit;

    assign ld = agent_ldest[g*ID_W +: ID_W];
    assign md = agent_model[g*FMT_W +: FMT_W];

    always_comb begin
      phys_hit = (dest == BCAST) || (dest == IDX);
      flat_hit = |(dest & ld);
      clus_hit = (dest[ID_W-1:HALF] == ld[ID_W-1:HALF]) &&
                 (|(dest[HALF-1:0] & ld[HALF-1:0]));
      if (md == FMT_FLAT)      log_hit = flat_hit;
      else if (md == FMT_CLUS) log_hit = clus_hit;
      else                     log_hit = 1'b0;
      addr_hit[g] = logical ? log_hit : phys_hit;
    end
  end

endmodule

// File: rtl/ipi_target_filter.sv
module ipi_target_filter
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 16
) (
  input  logic [N_AGENTS-1:0] addr_hit,
  input  shorthand_e          sh,
  input  logic [ID_W-1:0]     sender_id,
  input  logic [2:0]          mode,
  input  logic                level,
  input  logic                trigger,
  output logic [N_AGENTS-1:0] tgt_mask,
  output logic                deassert
);

  localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

  logic [N_AGENTS-1:0] self_hit;
  logic [N_AGENTS-1:0] base;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_self
    localparam logic [ID_W-1:0] IDX = ID_W'(g);
    assign self_hit[g] = (sender_id == IDX);
  end

  always_comb begin
    unique case (sh)
      SH_FIELD:  base = addr_hit;
      SH_SELF:   base = self_hit;
      SH_ALL:    base = '1;
      SH_OTHERS: base = ~self_hit;
      default:   base = '0;
    endcase
  end

  always_comb begin
    deassert = (mode == DM_INIT) && !level && trigger;
    if (deassert)                tgt_mask = '0;
    else if (mode == DM_LOWEST)  tgt_mask = base & (~base + ONE);
    else                         tgt_mask = base;
  end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [31:0]               cmd_lo,
  input  logic [31:0]               cmd_hi,
  input  logic [7:0]                sender_id,
  input  logic [N_AGENTS*8-1:0]     agent_ldest,
  input  logic [N_AGENTS*4-1:0]     agent_model,
  output logic                      out_valid,
  output logic [N_AGENTS-1:0]       out_mask,
  output logic                      out_empty,
  output logic [7:0]                out_vector,
  output logic [2:0]                out_mode,
  output logic                      out_level,
  output logic                      out_trigger
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ipi_cmd_t            cmd;
  logic [N_AGENTS-1:0] addr_hit;
  logic [N_AGENTS-1:0] tgt_mask;
  logic                deassert;

  ipi_cmd_decode u_decode (
    .cmd_lo (cmd_lo),
    .cmd_hi (cmd_hi),
    .cmd    (cmd)
  );

  ipi_dest_match #(.N_AGENTS(N_AGENTS)) u_match (
    .dest        (cmd.dest),
    .logical     (cmd.logical),
    .agent_ldest (agent_ldest),
    .agent_model (agent_model),
    .addr_hit    (addr_hit)
  );

  ipi_target_filter #(.N_AGENTS(N_AGENTS)) u_filter (
    .addr_hit  (addr_hit),
    .sh        (cmd.sh),
    .sender_id (sender_id),
    .mode      (cmd.mode),
    .level     (cmd.level),
    .trigger   (cmd.trigger),
    .tgt_mask  (tgt_mask),
    .deassert  (deassert)
  );

  // Next-state
  logic                valid_d, empty_d, level_d, trig_d;
  logic [N_AGENTS-1:0] mask_d;
  logic [7:0]          vec_d;
  logic [2:0]          mode_d;
  logic                load_en;

  assign load_en = cmd_valid;

  always_comb begin
    valid_d = load_en;
    mask_d  = out_mask;
    empty_d = out_empty;
    vec_d   = out_vector;
    mode_d  = out_mode;
    level_d = out_level;
    trig_d  = out_trigger;
    if (load_en) begin
      mask_d  = tgt_mask;
      empty_d = ~|tgt_mask;
      vec_d   = cmd.vector;
      mode_d  = cmd.mode;
      level_d = cmd.level;
      trig_d  = cmd.trigger;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid   <= 1'b0;
      out_mask    <= '0;
      out_empty   <= 1'b0;
      out_vector  <= '0;
      out_mode    <= '0;
      out_level   <= 1'b0;
      out_trigger <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_mask    <= mask_d;
      out_empty   <= empty_d;
      out_vector  <= vec_d;
      out_mode    <= mode_d;
      out_level   <= level_d;
      out_trigger <= trig_d;
    end
  end

  // Assertions
  a_r11_valid_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cmd_valid));

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !out_valid && $stable(out_mask) && $stable(out_vector));

  a_r12_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_empty == (out_mask == '0)));

  a_r9_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == DM_LOWEST) |-> $onehot0(out_mask));

  a_r10_deassert_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == DM_INIT && !out_level && out_trigger) |-> out_empty);

  a_r7_all_agents: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rst_int_n && cmd.sh == SH_ALL && cmd.mode != DM_LOWEST && !deassert)
      |=> (out_mask == '1));

  a_r6_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rst_int_n && cmd.sh == SH_SELF && !deassert &&
     int'(sender_id) < N_AGENTS) |=> ($countones(out_mask) == 1));

  a_r13_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (!out_valid && out_mask == '0));

endmodule

// File: tb/sim_ipi_dest_resolver.sv
module sim_ipi_dest_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [31:0]   cmd_lo, cmd_hi;
  logic [7:0]    sender_id;
  logic [N*8-1:0] agent_ldest;
  logic [N*4-1:0] agent_model;
  logic          out_valid, out_empty, out_level, out_trigger;
  logic [N-1:0]  out_mask;
  logic [7:0]    out_vector;
  logic [2:0]    out_mode;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dest_resolver #(.N_AGENTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lo(cmd_lo),
    .cmd_hi(cmd_hi), .sender_id(sender_id), .agent_ldest(agent_ldest),
    .agent_model(agent_model), .out_valid(out_valid), .out_mask(out_mask),
    .out_empty(out_empty), .out_vector(out_vector), .out_mode(out_mode),
    .out_level(out_level), .out_trigger(out_trigger)
  );

  // Expected mask built from the requirements
  function automatic logic [N-1:0] exp_mask(input logic [31:0] lo,
                                             input logic [31:0] hi,
                                             input logic [7:0] sid);
    logic [N-1:0] m;
    logic [N-1:0] pick;
    logic [7:0]   dst;
    logic [7:0]   ld;
    logic [3:0]   md;
    bit           found;
    dst = hi[31:24];
    m = '0;
    for (int i = 0; i < N; i++) begin
      ld = agent_ldest[i*8 +: 8];
      md = agent_model[i*4 +: 4];
      case (lo[19:18])
        2'd0: begin
          if (!lo[11]) m[i] = (dst == 8'hFF) || (int'(dst) == i);  // R2, R3
          else if (md == 4'hF) m[i] = (dst & ld) != 8'h00;           // R4
          else if (md == 4'h0) m[i] = (dst[7:4] == ld[7:4]) &&
                                      ((dst[3:0] & ld[3:0]) != 4'h0); // R5
          else m[i] = 1'b0;
        end
        2'd1: m[i] = (int'(sid) == i);   // R6
        2'd2: m[i] = 1'b1;               // R7
        default: m[i] = (int'(sid) != i); // R8
      endcase
    end
    if (lo[10:8] == 3'd5 && !lo[14] && lo[15]) m = '0;  // R10
    else if (lo[10:8] == 3'd1) begin                     // R9
      pick = '0; found = 0;
      for (int i = 0; i < N; i++)
        if (m[i] && !found) begin pick[i] = 1'b1; found = 1; end
      m = pick;
    end
    return m;
  endfunction

  function automatic string mask_tag(input logic [31:0] lo, input logic [31:0] hi);
    if (lo[10:8] == 3'd5 && !lo[14] && lo[15]) return "R10";
    if (lo[10:8] == 3'd1) return "R9";
    case (lo[19:18])
      2'd1: return "R6";
      2'd2: return "R7";
      2'd3: return "R8";
      default: ;
    endcase
    if (lo[11]) return "R4 or R5";
    if (hi[31:24] == 8'hFF) return "R3";
    return "R2";
  endfunction

  initial begin
    logic [2:0]   modes [4];
    logic [N-1:0] em, held;
    logic [14:0]  ef, gf;
    string        tag;
    modes[0] = 3'd0; modes[1] = 3'd1; modes[2] = 3'd5; modes[3] = 3'd6;
    for (int i = 0; i < N; i++) begin
      agent_ldest[i*8 +: 8] = 8'((i*37 + 11) & 8'hFF);
      agent_model[i*4 +: 4] = (i % 3 == 0) ? 4'hF : (i % 3 == 1) ? 4'h0 : 4'h7;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_lo = '0; cmd_hi = '0; sender_id = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_mask !== '0 || out_empty !== 1'b0) begin
      n_fail++;
      $display("FAIL R13: reset outputs valid=%b mask=%h empty=%b expected 0 0 0",
               out_valid, out_mask, out_empty);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int sh = 0; sh < 4; sh++)
      for (int dm = 0; dm < 2; dm++)
        for (int mi = 0; mi < 4; mi++)
          for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            dv = 8'(d);
            // Reserved bits filled with patterns (R1: they must not matter)
            cmd_lo = {~{dv, dv[3:0]}, 2'(sh), dv[3:2], dv[1], dv[2], dv[1:0],
                      1'(dm), modes[mi], dv ^ 8'h5A};
            cmd_hi = {dv, {3{dv ^ 8'hC3}}};
            sender_id = 8'((d * 7) % 20);
            cmd_valid = 1'b1;
            @(negedge clk);
            em = exp_mask(cmd_lo, cmd_hi, sender_id);
            ef = {cmd_lo[7:0], cmd_lo[10:8], cmd_lo[14], cmd_lo[15], 2'b00};
            gf = {out_vector, out_mode, out_level, out_trigger, 2'b00};
            n_checks++;
            tag = mask_tag(cmd_lo, cmd_hi);
            if (out_valid !== 1'b1) begin
              n_fail++;
              $display("FAIL R11: out_valid=%b expected 1", out_valid);
            end else if (gf !== ef) begin
              n_fail++;
              $display("FAIL R1: fields got %h expected %h", gf, ef);
            end else if (out_mask !== em) begin
              n_fail++;
              $display("FAIL %s: mask got %h expected %h (lo=%h hi=%h sid=%0d)",
                       tag, out_mask, em, cmd_lo, cmd_hi, sender_id);
            end else if (out_empty !== (em == '0)) begin
              n_fail++;
              $display("FAIL R12: empty got %b expected %b", out_empty, em == '0);
            end
            cmd_valid = 1'b0;
            cmd_lo = ~cmd_lo;
            cmd_hi = ~cmd_hi;
            held = out_mask;
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0 || out_mask !== held) begin
              n_fail++;
              $display("FAIL R11: idle valid=%b mask=%h expected 0 and %h",
                       out_valid, out_mask, held);
            end
          end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule